// File: doc/BRIEF.md
# Fixed Off-Time Current Chopper

This block decides, for one brushed DC motor full bridge, when the bridge must stop driving so that the winding current can decay. An external current-sense comparator produces a digital over-threshold flag. The flag is synchronised elsewhere and reaches this block as a plain synchronous input. While the bridge is driving, a trip ends the on phase. The block then holds a chop request for a fixed number of clock cycles and afterwards hands the bridge back to drive.

Every switching event the block causes makes the sense signal ring for a short time. For this reason the trip flag is disregarded for a blanking window after each such event. Switching events here are entering drive, entering the off phase and leaving it. Downstream gate logic reads the chop flag to switch the bridge into its decay state. The blanking flag can be used for observation or for qualification. Clearing the bridge enable, or asserting sleep, puts the block straight back into idle and clears both timers.

Top module: `offtime_chopper`

## Requirements
- R1: After reset `chopActive` and `blanking` are both 0.
- R2: On the first clock edge at which the block is active (`enable`=1 and `sleepN`=1) while idle, `blanking` goes to 1 and stays 1 for exactly BLANK_CYCLES cycles, with `chopActive` 0.
- R3: While `blanking` is 1 in the drive phase, `tripIn` has no effect: `chopActive` stays 0.
- R4: In the drive phase, when `tripIn` is 1 at an edge where `blanking` is 0, `chopActive` is 1 from that edge on.
- R5: `chopActive` stays 1 for exactly OFF_CYCLES cycles. `tripIn` has no effect during that time.
- R6: On the edge where the off-time ends, `chopActive` returns to 0 and `blanking` returns to 1 together.
- R7: If `tripIn` is held at 1 through a blanking window in the drive phase, `chopActive` rises exactly one cycle after `blanking` falls.
- R8: When `enable` is 0 at an edge, both outputs are 0 after that edge. They stay 0 whatever `tripIn` does while the block is inactive.
- R9: When `sleepN` is 0 at an edge, both outputs are 0 after that edge. On waking, a fresh R2 blanking window starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Bridge enable; 0 forces idle |
| sleepN | input | 1 | Active-low sleep; 0 forces idle |
| tripIn | input | 1 | Synchronous over-threshold flag from the sense comparator |
| chopActive | output | 1 | 1 while the fixed off-time runs |
| blanking | output | 1 | 1 while the trip flag is being disregarded |

## Verification
Both outputs are registered. An input sampled at one edge therefore shows at the outputs just after that same edge. Examples are a trip seen with blanking low, enable going low, or sleep asserting. The blanking window covers the BLANK_CYCLES edges that follow the start event. The off-time covers OFF_CYCLES edges, and its end coincides with a new blanking window. A trip held through blanking therefore reaches `chopActive` one edge after `blanking` has fallen. The bench drives and samples 1 ns after each rising edge. It counts the edges for which each flag remains high and compares that count with the parameter. Single-cycle latencies are checked at the first sample after the stimulus edge.

// File: rtl/chopper_pkg.sv
package chopper_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DRIVE,
    ST_OFF
  } chopState_t;

  // Strobes from the sequencer to the timer datapath
  typedef struct packed {
    logic clear;      // drop both timers to zero
    logic loadOff;    // start the off-time one-shot
    logic loadBlank;  // start a blanking window
  } chopStrobe_t;

endpackage

// File: rtl/chopper_timers.sv
module chopper_timers
  import chopper_pkg::*;
#(
  parameter int OFF_CYCLES   = 1500,
  parameter int BLANK_CYCLES = 160
) (
  input  logic        clk,
  input  logic        rstN,
  input  chopStrobe_t strobe,
  output logic        offLast,
  output logic        blankBusy
);

  localparam int OFF_W   = $clog2(OFF_CYCLES + 1);
  localparam int BLANK_W = $clog2(BLANK_CYCLES + 1);

  logic [OFF_W-1:0]   offCnt;
  logic [BLANK_W-1:0] blankCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                offCnt <= '0;
    else if (strobe.clear)    offCnt <= '0;
    else if (strobe.loadOff)  offCnt <= OFF_W'(OFF_CYCLES);
    else if (offCnt != '0)    offCnt <= offCnt - OFF_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 blankCnt <= '0;
    else if (strobe.clear)     blankCnt <= '0;
    else if (strobe.loadBlank) blankCnt <= BLANK_W'(BLANK_CYCLES);
    else if (blankCnt != '0)   blankCnt <= blankCnt - BLANK_W'(1);
  end

  assign offLast   = (offCnt == OFF_W'(1));
  assign blankBusy = (blankCnt != '0);

endmodule

// File: rtl/chopper_ctrl.sv
module chopper_ctrl
  import chopper_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic        sleepN,
  input  logic        tripIn,
  input  logic        offLast,
  input  logic        blankBusy,
  output chopStrobe_t strobe,
  output logic        chopActive
);

  chopState_t state, stateNext;
  logic active;

  assign active = enable && sleepN;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    if (!active) begin
      stateNext    = ST_IDLE;
      strobe.clear = 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: begin
          stateNext        = ST_DRIVE;
          strobe.loadBlank = 1'b1;
        end
        ST_DRIVE: begin
          if (tripIn && !blankBusy) begin
            stateNext        = ST_OFF;
            strobe.loadOff   = 1'b1;
            strobe.loadBlank = 1'b1;
          end
        end
        ST_OFF: begin
          if (offLast) begin
            stateNext        = ST_DRIVE;
            strobe.loadBlank = 1'b1;
          end
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign chopActive = (state == ST_OFF);

endmodule

// File: rtl/offtime_chopper.sv
module offtime_chopper
  import chopper_pkg::*;
#(
  parameter int OFF_CYCLES   = 1500,
  parameter int BLANK_CYCLES = 160
) (
  input  logic clk,
  input  logic rstN,
  input  logic enable,
  input  logic sleepN,
  input  logic tripIn,
  output logic chopActive,
  output logic blanking
);

  chopStrobe_t strobe;
  logic        offLast;
  logic        blankBusy;

  chopper_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .sleepN     (sleepN),
    .tripIn     (tripIn),
    .offLast    (offLast),
    .blankBusy  (blankBusy),
    .strobe     (strobe),
    .chopActive (chopActive)
  );

  chopper_timers #(
    .OFF_CYCLES   (OFF_CYCLES),
    .BLANK_CYCLES (BLANK_CYCLES)
  ) u_timers (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .offLast   (offLast),
    .blankBusy (blankBusy)
  );

  assign blanking = blankBusy;

endmodule

// File: rtl/chopper_checker.sv
module chopper_checker #(
  parameter int OFF_CYCLES   = 1500,
  parameter int BLANK_CYCLES = 160
) (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic sleepN,
  input logic tripIn,
  input logic chopActive,
  input logic blanking
);

  int unsigned chopLen;
  int unsigned blankLen;
  logic active;

  assign active = enable && sleepN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chopLen  <= 0;
      blankLen <= 0;
    end else begin
      chopLen  <= chopActive ? chopLen + 1 : 0;
      blankLen <= blanking ? blankLen + 1 : 0;
    end
  end

  AST_IDLE_WHEN_INACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    !active |=> (!chopActive && !blanking));                                   // R8

  AST_TRIP_STARTS_CHOP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(chopActive) |-> ($past(tripIn) && !$past(blanking) && $past(active))); // R4

  AST_CHOP_LEN_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    chopActive |-> (chopLen < OFF_CYCLES));                                     // R5

  AST_CHOP_LEN_EXACT: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(chopActive) && $past(active)) |-> (chopLen == OFF_CYCLES));          // R5

  AST_REBLANK_ON_RETURN: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(chopActive) && $past(active)) |-> blanking);                         // R6

  AST_BLANK_LEN_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    blanking |-> (blankLen < BLANK_CYCLES));                                    // R2

endmodule

bind offtime_chopper chopper_checker #(
  .OFF_CYCLES   (OFF_CYCLES),
  .BLANK_CYCLES (BLANK_CYCLES)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .enable     (enable),
  .sleepN     (sleepN),
  .tripIn     (tripIn),
  .chopActive (chopActive),
  .blanking   (blanking)
);

// File: tb/test_offtime_chopper.sv
`timescale 1ns/1ps
module test_offtime_chopper;

  localparam int OFF   = 1500;
  localparam int BLANK = 160;
  localparam int LIMIT = 5000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic sleepN = 1'b1;
  logic tripIn = 1'b0;
  logic chopActive;
  logic blanking;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;

  offtime_chopper #(.OFF_CYCLES(OFF), .BLANK_CYCLES(BLANK)) i_offtime_chopper (
    .clk(clk), .rstN(rstN), .enable(enable), .sleepN(sleepN),
    .tripIn(tripIn), .chopActive(chopActive), .blanking(blanking)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // advance n edges, then sit 1 ns past the last one
  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // count how many more samples a flag stays high (current sample included)
  task automatic countHigh(input bit useChop, output int n);
    n = 0;
    while ((useChop ? chopActive : blanking) && n < LIMIT) begin
      n++;
      step(1);
    end
  endtask

  task automatic goIdle();
    enable = 1'b0; tripIn = 1'b0; sleepN = 1'b1;
    step(2);
  endtask

  task automatic tReset();
    check(chopActive == 1'b0, "R1", "chopActive after reset", chopActive, 0);
    check(blanking == 1'b0, "R1", "blanking after reset", blanking, 0);
  endtask

  task automatic tStartBlank();
    int n;
    goIdle();
    enable = 1'b1;
    step(1);
    check(blanking == 1'b1, "R2", "blanking on start", blanking, 1);
    check(chopActive == 1'b0, "R2", "chop on start", chopActive, 0);
    countHigh(1'b0, n);
    check(n == BLANK, "R2", "blank length", n, BLANK);
  endtask

  task automatic tHeldTrip();
    int n;
    bit sawChop = 0;
    goIdle();
    enable = 1'b1; tripIn = 1'b1;
    step(1);
    n = 0;
    while (blanking && n < LIMIT) begin
      if (chopActive) sawChop = 1;
      n++;
      step(1);
    end
    check(sawChop == 0, "R3", "chop during blanking", sawChop, 0);
    check(chopActive == 1'b0, "R7", "chop at blank fall", chopActive, 0);
    step(1);
    check(chopActive == 1'b1, "R7", "chop one cycle after blank fall", chopActive, 1);
    tripIn = 1'b0;
  endtask

  task automatic tTripOff();
    int n;
    goIdle();
    enable = 1'b1;
    step(BLANK + 3);
    check(chopActive == 1'b0, "R4", "chop before trip", chopActive, 0);
    tripIn = 1'b1;
    step(1);
    tripIn = 1'b0;
    check(chopActive == 1'b1, "R4", "chop after trip", chopActive, 1);
    step(OFF / 2 - 1);
    tripIn = 1'b1;                       // R5: trip inside off-time
    step(3);
    tripIn = 1'b0;
    countHigh(1'b1, n);
    n = n + OFF / 2 + 2;
    check(n == OFF, "R5", "off-time length", n, OFF);
    check(blanking == 1'b1, "R6", "blanking at off end", blanking, 1);
  endtask

  task automatic tDisable();
    int bad = 0;
    goIdle();
    enable = 1'b1; tripIn = 1'b1;
    step(BLANK + 10);
    check(chopActive == 1'b1, "R8", "in off phase before disable", chopActive, 1);
    enable = 1'b0;
    step(1);
    check(chopActive == 1'b0 && blanking == 1'b0, "R8", "outputs after disable",
          {chopActive, blanking}, 0);
    for (int i = 0; i < 40; i++) begin
      step(1);
      if (chopActive || blanking) bad++;
    end
    check(bad == 0, "R8", "trip while disabled", bad, 0);
    tripIn = 1'b0;
  endtask

  task automatic tSleep();
    int n;
    goIdle();
    enable = 1'b1; tripIn = 1'b1;
    step(BLANK + 10);
    tripIn = 1'b0;
    sleepN = 1'b0;
    step(1);
    check(chopActive == 1'b0 && blanking == 1'b0, "R9", "outputs in sleep",
          {chopActive, blanking}, 0);
    step(5);
    sleepN = 1'b1;
    step(1);
    check(blanking == 1'b1 && chopActive == 1'b0, "R9", "fresh blank on wake",
          {chopActive, blanking}, 1);
    countHigh(1'b0, n);
    check(n == BLANK, "R9", "blank length after wake", n, BLANK);
  endtask

  initial begin
    #50000000;
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    step(3);
    tReset();
    rstN = 1'b1;
    step(2);
    tReset();
    tStartBlank();
    tHeldTrip();
    tTripOff();
    tDisable();
    tSleep();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule